// File: doc/BRIEF.md
# Clock-Gated Reset Sequencer

This block produces a clean start-up and recovery reset for several clock domains whose clocks come from a PLL through gated clock buffers. The controller runs on a free-running reference clock that is never gated. It has no reset input of its own: every register in it begins from a declared initial value. It waits until the PLL reports lock. It then switches off the enables of all gated clock buffers and applies one global active-low asynchronous reset while those clocks are stopped. After a settling interval it turns the clocks back on.

Each domain also gets its own reset synchronizer. The domain reset asserts at once when the global reset goes low, without any clock. It is released by a short flop chain clocked by that domain's own gated clock, so release happens only once the clock runs again. If lock is lost at any point after the sequence has begun, the controller stops the domain clocks and waits for lock before it runs the whole sequence again. The lock input passes through a two-flop synchronizer before the controller acts on it.

Top module: `rstseq_top`

## Requirements
- R1: After power-up, with no reset applied and lock low, `clk_en` is all zeros, `glob_rst_n` is 1, `seq_done` is 0 and `dom_rst_n` is all zeros. These values hold for as long as lock stays low.
- R2: Count the first rising `ref_clk` edge that samples `pll_locked` high as edge 1. If lock stays high, `glob_rst_n` goes low at edge OFF_WAIT+3. This includes every new lock after a loss of lock.
- R3: `clk_en` is all zeros whenever `glob_rst_n` is low.
- R4: With lock held, `glob_rst_n` stays low for exactly PULSE_W `ref_clk` cycles.
- R5: `clk_en` rises exactly SETTLE_W `ref_clk` cycles after `glob_rst_n` rises. All bits of `clk_en` change on the same edge.
- R6: `seq_done` rises one `ref_clk` cycle after `clk_en` rises. It is high only while `clk_en` is all ones, and it stays high until a loss of lock takes it down.
- R7: Count the first rising `ref_clk` edge that samples `pll_locked` low, after the sequence has started, as edge 1. At edge 3, `clk_en` is all zeros and `seq_done` is 0.
- R8: Every `dom_rst_n` bit is low whenever `glob_rst_n` is low. The bits go low at the same instant as the global reset, without any domain clock edge.
- R9: After `glob_rst_n` rises, each `dom_rst_n[i]` rises at the third rising edge of `dom_clk[i]`. Each domain is released independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock for the controller |
| pll_locked | input | 1 | PLL lock indication, asynchronous to `ref_clk` |
| dom_clk | input | N_DOM | Gated domain clocks as delivered by the clock buffers |
| clk_en | output | N_DOM | Enables for the gated clock buffers, one per domain |
| glob_rst_n | output | 1 | Global active-low asynchronous reset pulse |
| dom_rst_n | output | N_DOM | Per-domain active-low reset with synchronous release |
| seq_done | output | 1 | High once the clocks are running again after a full sequence |

## Verification
The lock input is driven with a long hold so that the sequence runs to completion. It is also dropped at chosen points: during the gating wait, inside the reset pulse, during settling, and just after completion. These cases show whether an abort restarts the whole ordered sequence or only part of it. Randomly timed lock pulses and gaps then mix full runs with aborted ones. Every global pulse is checked for its latency from lock and for its width, and every clock restart is checked against its settling gap. The three domain clocks have unrelated periods. This shows whether each domain reset is released by its own clock edges rather than by the reference clock.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  // Controller phases, binary coded; codes 5..7 are illegal and recover to ST_IDLE
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_GATE   = 3'd1,
    ST_PULSE  = 3'd2,
    ST_SETTLE = 3'd3,
    ST_RUN    = 3'd4
  } seq_state_t;

  // Largest of three phase lengths, used to size the shared phase counter
  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Counter width able to hold values 0 .. n
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rstseq_lock_sync.sv
module rstseq_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic din,
  output logic dout
);

  // Power-up value says "not locked" until real samples arrive
  logic [STAGES-1:0] chain = '0;

  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int N_DOM    = 3,
  parameter int OFF_WAIT = 4,
  parameter int PULSE_W  = 8,
  parameter int SETTLE_W = 6
) (
  input  logic             clk,
  input  logic             lock_ok,
  output logic [N_DOM-1:0] clk_en,
  output logic             grst_n,
  output logic             done,
  output logic             ev_lock_lost
);

  localparam int LONGEST = max3(OFF_WAIT, PULSE_W, SETTLE_W);
  localparam int CW      = cnt_bits(LONGEST);

  // All state starts from declared values; there is no reset input
  seq_state_t     st      = ST_IDLE;
  seq_state_t     nxt;
  logic [CW-1:0]  cnt     = '0;
  logic [CW-1:0]  cnt_nxt;
  logic           en_q    = 1'b0;
  logic           grst_q  = 1'b1;
  logic           done_q  = 1'b0;
  logic           phase_end;

  function automatic int phase_len(input seq_state_t s);
    case (s)
      ST_GATE:   return OFF_WAIT;
      ST_PULSE:  return PULSE_W;
      ST_SETTLE: return SETTLE_W;
      default:   return 1;
    endcase
  endfunction

  assign ev_lock_lost = !lock_ok && (st != ST_IDLE);
  assign phase_end    = (32'(cnt) == phase_len(st) - 1);

  always_comb begin
    nxt     = st;
    cnt_nxt = cnt + 1'b1;
    case (st)
      ST_IDLE: begin
        cnt_nxt = '0;
        if (lock_ok) nxt = ST_GATE;
      end
      ST_GATE: begin
        if (phase_end) begin
          nxt     = ST_PULSE;
          cnt_nxt = '0;
        end
      end
      ST_PULSE: begin
        if (phase_end) begin
          nxt     = ST_SETTLE;
          cnt_nxt = '0;
        end
      end
      ST_SETTLE: begin
        if (phase_end) begin
          nxt     = ST_RUN;
          cnt_nxt = '0;
        end
      end
      ST_RUN: begin
        cnt_nxt = '0;
      end
      default: begin
        nxt     = ST_IDLE;
        cnt_nxt = '0;
      end
    endcase
    if (ev_lock_lost) begin
      nxt     = ST_IDLE;
      cnt_nxt = '0;
    end
  end

  // Outputs are registered from the next state so that buffer enables and
  // the global reset leave flops directly, free of decode glitches
  always_ff @(posedge clk) begin
    st     <= nxt;
    cnt    <= cnt_nxt;
    en_q   <= (nxt == ST_RUN);
    grst_q <= (nxt != ST_PULSE);
    done_q <= en_q && (nxt == ST_RUN);
  end

  assign clk_en = {N_DOM{en_q}};
  assign grst_n = grst_q;
  assign done   = done_q;

endmodule

// File: rtl/rstseq_dom_sync.sv
module rstseq_dom_sync #(
  parameter int STAGES = 3
) (
  input  logic dclk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] chain = '0;

  // Assertion needs no clock; release ripples in on the domain's own edges
  always_ff @(posedge dclk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain[STAGES-1];

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top #(
  parameter int N_DOM       = 3,
  parameter int OFF_WAIT    = 4,
  parameter int PULSE_W     = 8,
  parameter int SETTLE_W    = 6,
  parameter int LOCK_STAGES = 2,
  parameter int REL_STAGES  = 3
) (
  input  logic             ref_clk,
  input  logic             pll_locked,
  input  logic [N_DOM-1:0] dom_clk,
  output logic [N_DOM-1:0] clk_en,
  output logic             glob_rst_n,
  output logic [N_DOM-1:0] dom_rst_n,
  output logic             seq_done
);

  // Named internal events, observed by the bound checker
  logic lock_ok;
  logic ev_lock_lost;

  rstseq_lock_sync #(.STAGES(LOCK_STAGES)) u_lock_sync (
    .clk  (ref_clk),
    .din  (pll_locked),
    .dout (lock_ok)
  );

  rstseq_fsm #(
    .N_DOM    (N_DOM),
    .OFF_WAIT (OFF_WAIT),
    .PULSE_W  (PULSE_W),
    .SETTLE_W (SETTLE_W)
  ) u_fsm (
    .clk          (ref_clk),
    .lock_ok      (lock_ok),
    .clk_en       (clk_en),
    .grst_n       (glob_rst_n),
    .done         (seq_done),
    .ev_lock_lost (ev_lock_lost)
  );

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    rstseq_dom_sync #(.STAGES(REL_STAGES)) u_dom_sync (
      .dclk   (dom_clk[d]),
      .arst_n (glob_rst_n),
      .rst_n  (dom_rst_n[d])
    );
  end

endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
  parameter int N_DOM = 3
) (
  input logic             ref_clk,
  input logic             lock_ok,
  input logic             ev_lock_lost,
  input logic [N_DOM-1:0] clk_en,
  input logic             glob_rst_n,
  input logic [N_DOM-1:0] dom_rst_n,
  input logic             seq_done
);

  // No reset exists; properties are held off until one edge has passed
  logic live = 1'b0;
  always_ff @(posedge ref_clk) live <= 1'b1;

  // R3
  en_off_in_pulse_chk: assert property (@(posedge ref_clk) disable iff (!live)
    !glob_rst_n |-> (clk_en == '0));

  // R3
  gate_before_pulse_chk: assert property (@(posedge ref_clk) disable iff (!live)
    $fell(glob_rst_n) |-> ($past(clk_en) == '0));

  // R5
  en_uniform_chk: assert property (@(posedge ref_clk) disable iff (!live)
    (clk_en == '0) || (&clk_en));

  // R6
  done_needs_en_chk: assert property (@(posedge ref_clk) disable iff (!live)
    seq_done |-> (&clk_en));

  // R6
  done_after_en_chk: assert property (@(posedge ref_clk) disable iff (!live)
    $rose(seq_done) |-> $past(&clk_en));

  // R7
  lock_lost_gates_chk: assert property (@(posedge ref_clk) disable iff (!live)
    ev_lock_lost |=> ((clk_en == '0) && !seq_done));

  // R7
  no_start_unlocked_chk: assert property (@(posedge ref_clk) disable iff (!live)
    $fell(glob_rst_n) |-> $past(lock_ok));

  // R8
  dom_low_in_pulse_chk: assert property (@(posedge ref_clk) disable iff (!live)
    !glob_rst_n |-> (dom_rst_n == '0));

endmodule

bind rstseq_top rstseq_chk #(.N_DOM(N_DOM)) i_rstseq_chk (
  .ref_clk      (ref_clk),
  .lock_ok      (lock_ok),
  .ev_lock_lost (ev_lock_lost),
  .clk_en       (clk_en),
  .glob_rst_n   (glob_rst_n),
  .dom_rst_n    (dom_rst_n),
  .seq_done     (seq_done)
);

// File: tb/test_rstseq_top.sv
`timescale 1ns/1ps
module test_rstseq_top;

  localparam int ND = 3;
  localparam int OW = 4;
  localparam int PW = 8;
  localparam int SW = 6;
  localparam int FULL = 3 + OW + PW + SW + 1;

  logic          ref_clk = 1'b0;
  logic          pll_locked = 1'b0;
  logic [ND-1:0] gclk;
  logic [ND-1:0] clk_en;
  logic          glob_rst_n;
  logic [ND-1:0] dom_rst_n;
  logic          seq_done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int lock_rise_cyc = -1000;
  int lock_drop_cyc = -1000;
  int fall_cyc = -1000;
  int rise_cyc = -1000;
  int en_rise_cyc = -1000;

  always #10 ref_clk = ~ref_clk;
  always @(posedge ref_clk) cyc++;

  rstseq_top #(.N_DOM(ND), .OFF_WAIT(OW), .PULSE_W(PW), .SETTLE_W(SW),
               .LOCK_STAGES(2), .REL_STAGES(3)) i_rstseq_top (
    .ref_clk    (ref_clk),
    .pll_locked (pll_locked),
    .dom_clk    (gclk),
    .clk_en     (clk_en),
    .glob_rst_n (glob_rst_n),
    .dom_rst_n  (dom_rst_n),
    .seq_done   (seq_done)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected latencies restated from the requirements
  function automatic int exp_lock_to_pulse();
    return OW + 3;
  endfunction
  function automatic int exp_loss_to_gate();
    return 3;
  endfunction

  // Gated clock buffer models with glitch-free enable latching, plus R9 monitors
  for (genvar g = 0; g < ND; g++) begin : g_dom
    logic fc = 1'b0;
    logic el = 1'b0;
    int   edges = 0;
    bit   seen = 1'b1;
    always #(4 + 3 * g + g * g) fc = ~fc;
    always @(negedge fc) el <= clk_en[g];
    assign gclk[g] = fc & el;
    always @(negedge glob_rst_n) begin
      edges = 0;
      seen  = 1'b0;
    end
    always @(posedge gclk[g]) begin
      edges++;
      #1;
      if (!seen && dom_rst_n[g]) begin
        seen = 1'b1;
        check($sformatf("R9 dom%0d release edge", g), edges, 3);
      end
    end
  end

  // Monitor, sampling away from the active edge
  logic          p_grst = 1'b1;
  logic          p_done = 1'b0;
  logic [ND-1:0] p_en = '0;
  always @(negedge ref_clk) begin
    if (!glob_rst_n) check("R3 enables off in pulse", clk_en, 0);
    if (!glob_rst_n) check("R8 domains low in pulse", dom_rst_n, 0);
    if (p_grst && !glob_rst_n) begin
      fall_cyc = cyc;
      check("R2 lock to pulse", cyc - lock_rise_cyc, exp_lock_to_pulse());
      check("R8 immediate assert", dom_rst_n, 0);
    end
    if (!p_grst && glob_rst_n) begin
      if (lock_drop_cyc < fall_cyc - 2) check("R4 pulse width", cyc - fall_cyc, PW);
      rise_cyc = cyc;
    end
    if (p_en == '0 && clk_en != '0) begin
      check("R5 settle gap", cyc - rise_cyc, SW);
      check("R5 all enables", clk_en, {ND{1'b1}});
      en_rise_cyc = cyc;
    end
    if (!p_done && seq_done) check("R6 done delay", cyc - en_rise_cyc, 1);
    if (p_done && !seq_done) check("R6 done held until loss", cyc - lock_drop_cyc, exp_loss_to_gate());
    if (cyc == lock_drop_cyc + exp_loss_to_gate()) begin
      check("R7 enables off", clk_en, 0);
      check("R7 done low", seq_done, 0);
    end
    p_grst = glob_rst_n;
    p_done = seq_done;
    p_en   = clk_en;
  end

  task automatic set_lock(input bit v);
    @(negedge ref_clk);
    pll_locked = v;
    if (v) lock_rise_cyc = cyc;
    else   lock_drop_cyc = cyc;
  endtask

  task automatic episode(input int hold, input int gap);
    set_lock(1'b1);
    repeat (hold) @(negedge ref_clk);
    set_lock(1'b0);
    repeat (gap) @(negedge ref_clk);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2417);
    #5;
    // R1 power-up values
    check("R1 enables", clk_en, 0);
    check("R1 global reset", glob_rst_n, 1);
    check("R1 done", seq_done, 0);
    check("R1 domain resets", dom_rst_n, 0);
    repeat (20) @(negedge ref_clk);
    check("R1 idle enables", clk_en, 0);
    check("R1 idle global reset", glob_rst_n, 1);
    check("R1 idle domain resets", dom_rst_n, 0);
    // Full run, then aborts in each phase
    episode(FULL + 30, 10);
    check("R9 all domains released", dom_rst_n, {ND{1'b1}});
    episode(3 + 2, 6);
    episode(3 + OW + 3, 6);
    episode(3 + OW + PW + 2, 6);
    episode(FULL + 40, 8);
    episode(FULL, 5);
    // Randomly timed lock pulses
    for (int k = 0; k < 24; k++) begin
      episode($urandom_range(1, FULL + 15), $urandom_range(4, 12));
    end
    episode(FULL + 40, 6);
    check("R9 final domains released", dom_rst_n, {ND{1'b1}});
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule